// File: doc/BRIEF.md
# Predicated Writeback Annul Stage

This block is the last stage of a simple in-order datapath in which every instruction may be predicated. Each result arriving from the functional units carries a destination register, a data word, an optional predicate register, a condition register, three flags (move-if-zero, move-if-nonzero, guarded load) and an exception request with its class. The stage reads the predicate and condition registers from its own register file and decides whether the write commits. It also decides whether the exception is reported or the slot is annulled.

Annulment is late: a slot whose predicate or guard fails has already been spent in its functional unit, and it is counted here. A disabled instruction writes nothing and reports no exception of either class. An enabled instruction that requests an exception reports it exactly as an unpredicated one would, and its write is dropped. Commits go through a one-entry pending-write register before they reach the register file. Predicate and condition reads forward from that entry, so back-to-back dependent instructions see the newest value. A read port lets the architectural register contents be observed.

Top module: `pred_wb_stage`

## Requirements
- R1: An accepted instruction with no flags, an enabled predicate and no exception request writes `in_data` to `in_dst`. The new value is readable on `rd_data` from the second rising edge after acceptance.
- R2: The enable is true when `in_pred_use` is 0, or when the register selected by `in_pred` holds a nonzero value. When the enable is false, no register changes.
- R3: With `in_cmovz` set, the write happens only when the register selected by `in_cond` is zero. `in_cmovz` takes priority over the other two flags.
- R4: With `in_cmovn` set and `in_cmovz` clear, the write happens only when the condition register is nonzero.
- R5: With `in_cload` set and both move flags clear, the write happens only when the condition register is nonzero.
- R6: An instruction whose predicate or guard fails never asserts `exc_valid`, whatever its `in_exc_cls` (0 = resumable, 1 = terminating).
- R7: An enabled instruction with `in_exc` set asserts `exc_valid` for one cycle after the accepting edge, with `exc_cls` and `exc_dst` copied from the instruction, and it writes no register.
- R8: `annul_cnt` increments by one on the edge that accepts each valid instruction whose predicate or guard fails. It wraps modulo 2^CNT_W and holds otherwise.
- R9: Register 0 always reads zero, and writes to it are discarded.
- R10: The predicate and condition reads of an instruction see the write committed by the instruction accepted one cycle earlier.
- R11: After reset, every register reads zero, `exc_valid` is 0 and `annul_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Incoming result present this cycle |
| in_dst | input | IW | Destination register index |
| in_data | input | DW | Result value |
| in_pred_use | input | 1 | 1: the instruction is predicated on `in_pred` |
| in_pred | input | IW | Predicate register index |
| in_cond | input | IW | Condition/guard register index |
| in_cmovz | input | 1 | Move-if-zero flag |
| in_cmovn | input | 1 | Move-if-nonzero flag |
| in_cload | input | 1 | Guarded-load flag |
| in_exc | input | 1 | Exception requested by the functional unit |
| in_exc_cls | input | 1 | Exception class: 0 resumable, 1 terminating |
| rd_idx | input | IW | Observation read index |
| rd_data | output | DW | Architectural contents of register `rd_idx` |
| exc_valid | output | 1 | Exception report, one-cycle pulse |
| exc_cls | output | 1 | Class of the reported exception |
| exc_dst | output | IW | Destination index of the faulting instruction |
| annul_cnt | output | CNT_W | Count of annulled slots |

## Verification
The hardest case to reach is a dependent pair: the second instruction's predicate or condition comes from a write that is still in the pending entry and has not reached the register file. The bench issues writes and dependent instructions on consecutive cycles with no idle cycle between them, in both the enabling and the disabling direction. Around this it sweeps every combination of predicate use, predicate value, flag, condition value and exception class against two seeded registers, one zero and one nonzero. It also checks the flag priority, register 0 and a full wrap of the annul counter.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

  typedef enum logic {
    EXC_RESUMABLE   = 1'b0,
    EXC_TERMINATING = 1'b1
  } exc_class_e;

  // Predicate: unpredicated instructions are always enabled.
  function automatic logic f_pred_ok(input logic use_pred, input logic pred_nz);
    return !use_pred || pred_nz;
  endfunction

  // Guard from the operation flags; move-if-zero wins, then move-if-nonzero, then guarded load.
  function automatic logic f_guard_ok(input logic cmovz, input logic cmovn,
                                      input logic cload, input logic cond_nz);
    if (cmovz)      return !cond_nz;
    else if (cmovn) return cond_nz;
    else if (cload) return cond_nz;
    else            return 1'b1;
  endfunction

endpackage

// File: rtl/pwb_regfile.sv
module pwb_regfile #(
  parameter int NREG = 8,
  parameter int DW   = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem [NREG];
  logic          wr_live;

  assign wr_live = wr_en && (wr_idx != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (wr_live) begin
      mem[wr_idx] <= wr_data;
    end
  end

  // Forwarding read from the pending write.
  function automatic logic [DW-1:0] f_fwd(input logic [IW-1:0] idx, input logic [DW-1:0] stored,
                                          input logic live, input logic [IW-1:0] widx,
                                          input logic [DW-1:0] wdata);
    if (idx == '0)                 return '0;
    else if (live && widx == idx)  return wdata;
    else                           return stored;
  endfunction

  assign ra_data = f_fwd(ra_idx, mem[ra_idx], wr_live, wr_idx, wr_data);
  assign rb_data = f_fwd(rb_idx, mem[rb_idx], wr_live, wr_idx, wr_data);
  assign rd_data = (rd_idx == '0) ? '0 : mem[rd_idx];

  p_zero_reads_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> (rd_data == '0));

  p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_live |=> (mem[$past(wr_idx)] == $past(wr_data)));

endmodule

// File: rtl/pwb_decide.sv
module pwb_decide (
  input  logic valid,
  input  logic pred_use,
  input  logic pred_nz,
  input  logic cond_nz,
  input  logic cmovz,
  input  logic cmovn,
  input  logic cload,
  input  logic exc_req,
  output logic commit,
  output logic raise,
  output logic annul
);
  import pwb_pkg::*;

  logic enable;

  assign enable = f_pred_ok(pred_use, pred_nz) && f_guard_ok(cmovz, cmovn, cload, cond_nz);
  assign commit = valid && enable && !exc_req;
  assign raise  = valid && enable && exc_req;
  assign annul  = valid && !enable;

endmodule

// File: rtl/pwb_annul_ctr.sv
module pwb_annul_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt == $past(cnt) + {{(CNT_W-1){1'b0}}, 1'b1}));

  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt));

endmodule

// File: rtl/pred_wb_stage.sv
module pred_wb_stage #(
  parameter int NREG  = 8,
  parameter int DW    = 16,
  parameter int CNT_W = 8,
  localparam int IW   = $clog2(NREG)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [IW-1:0]    in_dst,
  input  logic [DW-1:0]    in_data,
  input  logic             in_pred_use,
  input  logic [IW-1:0]    in_pred,
  input  logic [IW-1:0]    in_cond,
  input  logic             in_cmovz,
  input  logic             in_cmovn,
  input  logic             in_cload,
  input  logic             in_exc,
  input  logic             in_exc_cls,
  input  logic [IW-1:0]    rd_idx,
  output logic [DW-1:0]    rd_data,
  output logic             exc_valid,
  output logic             exc_cls,
  output logic [IW-1:0]    exc_dst,
  output logic [CNT_W-1:0] annul_cnt
);
  import pwb_pkg::*;

  // Pending write entry between the decision and the register file.
  logic          pend_we;
  logic [IW-1:0] pend_idx;
  logic [DW-1:0] pend_data;

  logic [DW-1:0] pred_val, cond_val;
  logic          commit_evt, raise_evt, annul_evt;

  pwb_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pend_we),
    .wr_idx  (pend_idx),
    .wr_data (pend_data),
    .ra_idx  (in_pred),
    .ra_data (pred_val),
    .rb_idx  (in_cond),
    .rb_data (cond_val),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  pwb_decide u_dec (
    .valid    (in_valid),
    .pred_use (in_pred_use),
    .pred_nz  (|pred_val),
    .cond_nz  (|cond_val),
    .cmovz    (in_cmovz),
    .cmovn    (in_cmovn),
    .cload    (in_cload),
    .exc_req  (in_exc),
    .commit   (commit_evt),
    .raise    (raise_evt),
    .annul    (annul_evt)
  );

  pwb_annul_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk   (clk),
    .rst_n (rst_n),
    .inc   (annul_evt),
    .cnt   (annul_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_we   <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
      exc_valid <= 1'b0;
      exc_cls   <= EXC_RESUMABLE;
      exc_dst   <= '0;
    end else begin
      pend_we   <= commit_evt;
      pend_idx  <= in_dst;
      pend_data <= in_data;
      exc_valid <= raise_evt;
      exc_cls   <= in_exc_cls;
      exc_dst   <= in_dst;
    end
  end

  p_annul_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
    annul_evt |=> !exc_valid);

  p_annul_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    annul_evt |=> !pend_we);

  p_exc_fields_r7: assert property (@(posedge clk) disable iff (!rst_n)
    raise_evt |=> (exc_valid && exc_dst == $past(in_dst) && exc_cls == $past(in_exc_cls) && !pend_we));

  p_exc_origin_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_evt |=> !exc_valid);

endmodule

// File: tb/tb_pred_wb_stage.sv
module tb_pred_wb_stage;
  localparam int NREG = 8, DW = 16, CNT_W = 8, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_pred_use = 0, in_cmovz = 0, in_cmovn = 0, in_cload = 0;
  logic in_exc = 0, in_exc_cls = 0;
  logic [IW-1:0] in_dst = '0, in_pred = '0, in_cond = '0, rd_idx = '0;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] rd_data;
  logic exc_valid, exc_cls;
  logic [IW-1:0] exc_dst;
  logic [CNT_W-1:0] annul_cnt;

  pred_wb_stage #(.NREG(NREG), .DW(DW), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dst(in_dst), .in_data(in_data),
    .in_pred_use(in_pred_use), .in_pred(in_pred), .in_cond(in_cond), .in_cmovz(in_cmovz),
    .in_cmovn(in_cmovn), .in_cload(in_cload), .in_exc(in_exc), .in_exc_cls(in_exc_cls),
    .rd_idx(rd_idx), .rd_data(rd_data), .exc_valid(exc_valid), .exc_cls(exc_cls),
    .exc_dst(exc_dst), .annul_cnt(annul_cnt));

  always #5 clk = ~clk;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [DW-1:0] m_rf [NREG];
  logic [CNT_W-1:0] m_cnt = '0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, got %0d cycles expected fewer", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [DW-1:0] mval(input int i);
    return (i == 0) ? '0 : m_rf[i];
  endfunction

  // Drive one instruction, accept it on the next edge, check the exception report and counter.
  task automatic issue(input string req, input int dst, input logic [DW-1:0] data,
                       input logic puse, input int pidx, input int cidx,
                       input logic fz, input logic fn, input logic fl,
                       input logic ex, input logic cls);
    logic en, guard, cnz;
    cnz = (mval(cidx) != 0);
    if (fz)      guard = !cnz;
    else if (fn) guard = cnz;
    else if (fl) guard = cnz;
    else         guard = 1'b1;
    en = (!puse || mval(pidx) != 0) && guard;
    in_valid = 1; in_dst = IW'(dst); in_data = data; in_pred_use = puse;
    in_pred = IW'(pidx); in_cond = IW'(cidx); in_cmovz = fz; in_cmovn = fn;
    in_cload = fl; in_exc = ex; in_exc_cls = cls;
    @(posedge clk); @(negedge clk);
    in_valid = 0;
    if (en && !ex && dst != 0) m_rf[dst] = data;
    if (!en) m_cnt = m_cnt + 1'b1;
    chk({req, " exc_valid"}, 32'(exc_valid), 32'(en && ex));
    if (en && ex) begin
      chk({req, " exc_cls R7"}, 32'(exc_cls), 32'(cls));
      chk({req, " exc_dst R7"}, 32'(exc_dst), 32'(dst));
    end
    chk({req, " annul_cnt R8"}, 32'(annul_cnt), 32'(m_cnt));
  endtask

  task automatic drain_and_compare(input string req);
    @(posedge clk); @(negedge clk);
    chk({req, " exc pulse ends R7"}, 32'(exc_valid), 32'(0));
    for (int i = 0; i < NREG; i++) begin
      rd_idx = IW'(i); #1;
      chk({req, " regfile"}, 32'(rd_data), 32'(mval(i)));
    end
  endtask

  initial begin
    for (int i = 0; i < NREG; i++) m_rf[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R11 reset state
    chk("R11 exc_valid", 32'(exc_valid), 0);
    chk("R11 annul_cnt", 32'(annul_cnt), 0);
    for (int i = 0; i < NREG; i++) begin
      rd_idx = IW'(i); #1; chk("R11 reg", 32'(rd_data), 0);
    end

    // Seed register 1 nonzero (R1)
    issue("R1 seed", 1, 16'h00A5, 0, 0, 0, 0, 0, 0, 0, 0);
    drain_and_compare("R1 seed");

    // Sweep: predicate use, predicate reg, op, condition reg, exception kind
    begin
      int n = 0;
      for (int pu = 0; pu < 2; pu++)
        for (int pi = 0; pi < 2; pi++)
          for (int op = 0; op < 4; op++)
            for (int ci = 0; ci < 2; ci++)
              for (int ek = 0; ek < 3; ek++) begin
                string tag;
                tag = (op == 0) ? "R1/R2" : (op == 1) ? "R3" : (op == 2) ? "R4" : "R5";
                if (ek != 0) tag = {tag, " R6/R7"};
                issue(tag, 2 + (n % 6), DW'(16'h0100 + n), pu[0], pi, ci,
                      op == 1, op == 2, op == 3, ek != 0, ek == 2);
                drain_and_compare(tag);
                n++;
              end
    end

    // R3 priority: both move flags set, condition nonzero -> move-if-zero wins, no write
    issue("R3 priority", 4, 16'hBEEF, 0, 0, 1, 1, 1, 0, 0, 0);
    drain_and_compare("R3 priority");

    // R9: write to register 0 discarded; predicate on register 0 is false
    issue("R9 write r0", 0, 16'hFFFF, 0, 0, 0, 0, 0, 0, 0, 0);
    drain_and_compare("R9 write r0");
    issue("R9 pred r0", 5, 16'h1234, 1, 0, 0, 0, 0, 0, 0, 0);
    drain_and_compare("R9 pred r0");

    // R10: back-to-back dependence through the pending write
    issue("R10 clr", 3, 16'h0000, 0, 0, 0, 0, 0, 0, 0, 0);
    issue("R10 pred on fresh zero", 6, 16'h0666, 1, 3, 0, 0, 0, 0, 0, 0);
    issue("R10 set", 3, 16'h0033, 0, 0, 0, 0, 0, 0, 0, 0);
    issue("R10 pred on fresh nonzero", 7, 16'h0777, 1, 3, 0, 0, 0, 0, 0, 0);
    issue("R10 cmovz on fresh nonzero", 2, 16'h0222, 0, 0, 3, 1, 0, 0, 0, 0);
    issue("R10 cload on fresh nonzero", 4, 16'h0444, 0, 0, 3, 0, 0, 1, 0, 0);
    issue("R10 exc gated by fresh pred", 5, 16'h0555, 1, 3, 0, 0, 0, 0, 1, 1);
    drain_and_compare("R10");

    // R8 wrap: a full counter period of annulled slots, back to back
    for (int k = 0; k < (1 << CNT_W); k++)
      issue("R8 wrap", 2, 16'h0DEAD, 1, 0, 0, 0, 0, 0, 1, 1);
    drain_and_compare("R8 wrap");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule